// File: doc/BRIEF.md
# Pausable-Window Equality Monitor

This block is an on-line response checker meant to sit beside a design under observation. It watches a trigger line, a companion line and a pause input. Each rising edge of the trigger opens a check attempt. The attempt succeeds on the first cycle where the pause input is low and the trigger equals the companion. Cycles with the pause input high are frozen: nothing is compared and they do not count toward the window. An attempt fails once six unpaused cycles have gone by without a match.

Attempts that start on separate edges overlap freely. Each one is held in its own tracker slot, so they are judged independently. The monitor reports one-cycle pass and fail pulses and running pass and fail totals. A sticky overflow flag is raised when an edge finds every slot busy. The totals let a surrounding environment count outcomes, and the flag tells it that an attempt was lost.

Top module: `paused_window_monitor`

## Requirements
- R1: An attempt opens only on a cycle where the trigger is sampled high and was sampled low on the previous edge; the previous value reads as low after reset. Every output is registered and changes one cycle after the sample that decides it.
- R2: On the edge cycle itself the attempt counts as its first window cycle. If pause is low and the companion is high on that cycle, a pass pulse follows and no slot is used.
- R3: A live attempt passes on the first unpaused cycle where trigger equals companion, and its slot is freed on that cycle.
- R4: An attempt fails on its sixth unpaused cycle without a match, counting the edge cycle. The fail pulse follows that cycle, and no fail appears after only five such cycles.
- R5: A paused cycle makes no comparison and does not advance any attempt's count. No pass or fail pulse follows a paused cycle.
- R6: Attempts from separate edges are judged independently. With four slots by default, up to four unresolved attempts can be live at once.
- R7: When an edge neither resolves at once nor finds a free slot, the attempt is dropped and the overflow flag sets. The flag stays set until reset. A new edge takes the lowest-indexed slot that was free at the start of the cycle.
- R8: The pass and fail totals grow by the number of attempts that resolved in the deciding cycle. This count includes an attempt resolved on its own edge cycle.
- R9: An active-low reset clears every attempt, both pulses, both totals and the overflow flag, and reports no outcome for the cancelled attempts.
- R10: An unpaused cycle with trigger equal to companion is never followed by a fail pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Trigger line; its rising edge opens an attempt |
| comp | input | 1 | Companion line compared with the trigger |
| pause | input | 1 | High freezes all attempts for that cycle |
| passPulse | output | 1 | One-cycle pulse when one or more attempts pass |
| failPulse | output | 1 | One-cycle pulse when one or more attempts fail |
| overflow | output | 1 | Sticky flag: an attempt was dropped for lack of a slot |
| passCount | output | COUNT_W | Running total of passed attempts |
| failCount | output | COUNT_W | Running total of failed attempts |

## Verification
The assertions take for granted that trigger, companion and pause are synchronous to the clock and carry only known values at every rising edge. The properties that reach one cycle back, such as no pulse after a paused cycle and no fail after an unpaused match, rely on this. The stimulus gives every input a defined value before reset is released. It changes the inputs only on the falling edge, so each rising edge samples one settled combination of the three lines.

// File: rtl/pwin_pkg.sv
package pwin_pkg;

  // Per-slot strobes from control to datapath.
  typedef struct packed {
    logic load;        // occupy this slot with a new attempt
    logic advance;     // unpaused mismatch, bump the cycle count
    logic retirePass;  // matched on an unpaused cycle
    logic retireFail;  // window used up without a match
  } slotCmdT;

  // Strobes tied to the trigger edge itself.
  typedef struct packed {
    logic newPass;      // edge resolved on its own cycle
    logic loadCounted;  // the edge cycle counts as window cycle one
    logic setOverflow;  // edge needed a slot and none was free
  } edgeCmdT;

endpackage

// File: rtl/pwin_control.sv
module pwin_control
  import pwin_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int WINDOW = 6,
  parameter int CNT_W  = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         trig,
  input  logic                         comp,
  input  logic                         pause,
  input  logic [SLOTS-1:0]             slotValid,
  input  logic [SLOTS-1:0][CNT_W-1:0]  slotUsed,
  output slotCmdT [SLOTS-1:0]          slotCmd,
  output edgeCmdT                      edgeCmd
);

  localparam logic [CNT_W-1:0] LAST_USED = CNT_W'(WINDOW - 1);

  logic trigPrev;
  logic riseHit;
  logic enabled;
  logic matchNow;
  logic needSlot;
  logic [SLOTS-1:0] freeMask;
  logic [SLOTS-1:0] firstFree;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigPrev <= 1'b0;
    else       trigPrev <= trig;
  end

  assign riseHit  = trig & ~trigPrev;
  assign enabled  = ~pause;
  assign matchNow = ~(trig ^ comp);
  assign freeMask = ~slotValid;

  // Lowest-indexed free slot, one-hot.
  always_comb begin
    logic found;
    found     = 1'b0;
    firstFree = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (freeMask[i] && !found) begin
        firstFree[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  assign needSlot = riseHit & ~(enabled & matchNow);

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : gSlotCmd
      logic lastCycle;
      logic live;
      assign lastCycle  = (slotUsed[g] == LAST_USED);
      assign live       = slotValid[g] & enabled;
      assign slotCmd[g].load       = needSlot & firstFree[g];
      assign slotCmd[g].retirePass = live & matchNow;
      assign slotCmd[g].retireFail = live & ~matchNow & lastCycle;
      assign slotCmd[g].advance    = live & ~matchNow & ~lastCycle;
    end
  endgenerate

  assign edgeCmd.newPass     = riseHit & enabled & matchNow;
  assign edgeCmd.loadCounted = enabled;
  assign edgeCmd.setOverflow = needSlot & ~(|freeMask);

endmodule

// File: rtl/pwin_datapath.sv
module pwin_datapath
  import pwin_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int CNT_W   = 3,
  parameter int COUNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  slotCmdT [SLOTS-1:0]          slotCmd,
  input  edgeCmdT                      edgeCmd,
  output logic [SLOTS-1:0]             slotValid,
  output logic [SLOTS-1:0][CNT_W-1:0]  slotUsed,
  output logic                         passPulse,
  output logic                         failPulse,
  output logic                         overflow,
  output logic [COUNT_W-1:0]           passCount,
  output logic [COUNT_W-1:0]           failCount
);

  localparam int HIT_W = $clog2(SLOTS + 2);

  logic [HIT_W-1:0] passHits;
  logic [HIT_W-1:0] failHits;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : gSlot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotValid[g] <= 1'b0;
          slotUsed[g]  <= '0;
        end else if (slotCmd[g].load) begin
          slotValid[g] <= 1'b1;
          slotUsed[g]  <= CNT_W'(edgeCmd.loadCounted);
        end else if (slotCmd[g].retirePass || slotCmd[g].retireFail) begin
          slotValid[g] <= 1'b0;
        end else if (slotCmd[g].advance) begin
          slotUsed[g]  <= slotUsed[g] + 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    passHits = HIT_W'(edgeCmd.newPass);
    failHits = '0;
    for (int i = 0; i < SLOTS; i++) begin
      passHits = passHits + HIT_W'(slotCmd[i].retirePass);
      failHits = failHits + HIT_W'(slotCmd[i].retireFail);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passPulse <= 1'b0;
      failPulse <= 1'b0;
      overflow  <= 1'b0;
      passCount <= '0;
      failCount <= '0;
    end else begin
      passPulse <= (passHits != '0);
      failPulse <= (failHits != '0);
      overflow  <= overflow | edgeCmd.setOverflow;
      passCount <= passCount + COUNT_W'(passHits);
      failCount <= failCount + COUNT_W'(failHits);
    end
  end

endmodule

// File: rtl/paused_window_monitor.sv
module paused_window_monitor
  import pwin_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int WINDOW  = 6,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trig,
  input  logic               comp,
  input  logic               pause,
  output logic               passPulse,
  output logic               failPulse,
  output logic               overflow,
  output logic [COUNT_W-1:0] passCount,
  output logic [COUNT_W-1:0] failCount
);

  localparam int CNT_W = $clog2(WINDOW);

  slotCmdT [SLOTS-1:0]         slotCmd;
  edgeCmdT                     edgeCmd;
  logic [SLOTS-1:0]            slotValid;
  logic [SLOTS-1:0][CNT_W-1:0] slotUsed;

  pwin_control #(
    .SLOTS(SLOTS), .WINDOW(WINDOW), .CNT_W(CNT_W)
  ) u_control (
    .clk(clk), .rstN(rstN), .trig(trig), .comp(comp), .pause(pause),
    .slotValid(slotValid), .slotUsed(slotUsed),
    .slotCmd(slotCmd), .edgeCmd(edgeCmd)
  );

  pwin_datapath #(
    .SLOTS(SLOTS), .CNT_W(CNT_W), .COUNT_W(COUNT_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .slotCmd(slotCmd), .edgeCmd(edgeCmd),
    .slotValid(slotValid), .slotUsed(slotUsed),
    .passPulse(passPulse), .failPulse(failPulse), .overflow(overflow),
    .passCount(passCount), .failCount(failCount)
  );

endmodule

// File: rtl/pwin_assert.sv
module pwin_assert #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               trig,
  input logic               comp,
  input logic               pause,
  input logic               passPulse,
  input logic               failPulse,
  input logic               overflow,
  input logic [COUNT_W-1:0] passCount,
  input logic [COUNT_W-1:0] failCount
);

  assert_frozen_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(pause) |-> (!passPulse && !failPulse));

  assert_match_no_fail_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!pause) && $past(trig == comp)) |-> !failPulse);

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_overflow_on_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(trig));

  assert_pass_total_R8: assert property (@(posedge clk) disable iff (!rstN)
    !passPulse |-> (passCount == $past(passCount)));

  assert_fail_total_R8: assert property (@(posedge clk) disable iff (!rstN)
    !failPulse |-> (failCount == $past(failCount)));

  assert_fail_needs_mismatch_R4: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |-> ($past(trig) != $past(comp)));

endmodule

bind paused_window_monitor pwin_assert #(.COUNT_W(COUNT_W)) u_pwinAssert (.*);

// File: tb/test_paused_window_monitor.sv
module test_paused_window_monitor;

  localparam int SLOTS   = 4;
  localparam int WINDOW  = 6;
  localparam int COUNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trig = 1'b0;
  logic comp = 1'b0;
  logic pause = 1'b0;
  logic passPulse, failPulse, overflow;
  logic [COUNT_W-1:0] passCount, failCount;

  int total = 0;
  int fails = 0;

  // Reference state built from the requirements.
  bit mValid[SLOTS];
  int mUsed[SLOTS];
  bit mPrev;
  bit ePass, eFail, eOvf;
  int ePassCnt, eFailCnt;

  always #2 clk = ~clk;

  paused_window_monitor #(.SLOTS(SLOTS), .WINDOW(WINDOW), .COUNT_W(COUNT_W)) i_paused_window_monitor (
    .clk(clk), .rstN(rstN), .trig(trig), .comp(comp), .pause(pause),
    .passPulse(passPulse), .failPulse(failPulse), .overflow(overflow),
    .passCount(passCount), .failCount(failCount)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void modelReset();
    for (int i = 0; i < SLOTS; i++) begin mValid[i] = 0; mUsed[i] = 0; end
    mPrev = 0; ePass = 0; eFail = 0; eOvf = 0; ePassCnt = 0; eFailCnt = 0;
  endfunction

  // One sampled cycle: R1 edge, R2 same-cycle result, R3/R4/R5 per slot, R7 allocation, R8 totals.
  function automatic void modelStep(bit t, bit c, bit p);
    bit rise = t && !mPrev;
    bit freeAtStart[SLOTS];
    int np = 0;
    int nf = 0;
    bit placed = 0;
    for (int i = 0; i < SLOTS; i++) freeAtStart[i] = !mValid[i];
    for (int i = 0; i < SLOTS; i++) begin
      if (mValid[i] && !p) begin
        if (t == c) begin np++; mValid[i] = 0; end
        else if (mUsed[i] == WINDOW - 1) begin nf++; mValid[i] = 0; end
        else mUsed[i]++;
      end
    end
    if (rise) begin
      if (!p && t == c) np++;
      else begin
        for (int i = 0; i < SLOTS; i++) begin
          if (freeAtStart[i] && !placed) begin
            mValid[i] = 1; mUsed[i] = p ? 0 : 1; placed = 1;
          end
        end
        if (!placed) eOvf = 1;
      end
    end
    mPrev = t;
    ePass = (np > 0); eFail = (nf > 0);
    ePassCnt += np; eFailCnt += nf;
  endfunction

  task automatic compareModel(input string tag);
    chk({tag, " passPulse"}, int'(passPulse), int'(ePass));
    chk({tag, " failPulse"}, int'(failPulse), int'(eFail));
    chk({tag, " overflow"}, int'(overflow), int'(eOvf));
    chk({tag, " passCount"}, int'(passCount), ePassCnt);
    chk({tag, " failCount"}, int'(failCount), eFailCnt);
  endtask

  task automatic step(input bit t, input bit c, input bit p, input string tag);
    trig = t; comp = c; pause = p;
    modelStep(t, c, p);
    @(posedge clk);
    @(negedge clk);
    compareModel(tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    modelReset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 passPulse", int'(passPulse), 0);
    chk("R9 failPulse", int'(failPulse), 0);
    chk("R9 overflow", int'(overflow), 0);
    chk("R9 passCount", int'(passCount), 0);
    chk("R9 failCount", int'(failCount), 0);
    rstN = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd1234));
    @(negedge clk);
    doReset();

    // R2 edge resolves on its own cycle; R1 held trigger opens nothing new.
    step(1, 1, 0, "R2");
    chk("R2 immediate pass", int'(passPulse), 1);
    step(1, 1, 0, "R1");
    chk("R1 no second attempt while held", int'(passPulse), 0);
    step(0, 0, 0, "R1");

    // R4 six unpaused mismatches, edge cycle included.
    step(1, 0, 0, "R4");
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 0, "R4");
      chk("R4 no early fail", int'(failPulse), 0);
    end
    step(1, 0, 0, "R4");
    chk("R4 fail on sixth", int'(failPulse), 1);
    step(0, 0, 0, "R4");

    // R5 paused matches are ignored, R3 later unpaused match passes.
    step(1, 0, 0, "R3");
    step(1, 1, 1, "R5");
    chk("R5 paused match ignored", int'(passPulse), 0);
    step(1, 0, 0, "R3");
    step(1, 1, 0, "R3");
    chk("R3 first unpaused match", int'(passPulse), 1);
    step(0, 0, 0, "R3");

    // R5 paused mismatches do not count toward the window.
    step(1, 0, 0, "R5");
    for (int k = 0; k < 3; k++) step(1, 0, 1, "R5");
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 0, "R5");
      chk("R5 window frozen while paused", int'(failPulse), 0);
    end
    step(1, 0, 0, "R5");
    chk("R5 fail after six unpaused", int'(failPulse), 1);

    // R10 two live attempts meet an unpaused match.
    step(0, 0, 0, "R10");
    step(1, 0, 0, "R10");
    step(0, 1, 0, "R10");
    step(1, 0, 0, "R10");
    step(1, 1, 0, "R10");
    chk("R10 no fail on match", int'(failPulse), 0);
    chk("R6 both attempts pass", int'(passPulse), 1);

    // R7 fill all slots while paused, fifth edge overflows; R6/R8 five resolve together.
    step(0, 0, 1, "R7");
    for (int k = 0; k < 5; k++) begin
      step(1, 0, 1, "R7");
      chk("R7 overflow only on fifth edge", int'(overflow), (k == 4) ? 1 : 0);
      step(0, 0, 1, "R7");
    end
    base = int'(passCount);
    step(1, 1, 0, "R8");
    chk("R8 five attempts resolve at once", int'(passCount) - base, 5);
    chk("R6 independent attempts pass", int'(passPulse), 1);
    chk("R7 overflow sticky", int'(overflow), 1);

    // R9 reset cancels live attempts without reporting them.
    step(0, 0, 0, "R9");
    step(1, 0, 0, "R9");
    doReset();
    step(0, 0, 0, "R9");
    chk("R9 no outcome after reset", int'(failPulse) + int'(passPulse), 0);

    // Random traffic: R1 R3 R4 R5 R6 R7 R8 R10 against the model.
    for (int n = 0; n < 3000; n++) begin
      bit t = ($urandom % 2) == 1;
      bit c = ($urandom % 2) == 1;
      bit p = ($urandom % 3) == 0;
      step(t, c, p, "random R6");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule